// File: doc/BRIEF.md
# Four-Channel PWM Controller

This block generates four independent pulse-width-modulated outputs, configured through a small 32-bit register bus. Each channel has three registers: a control word, a high-time count and a cycle-length count. The control word holds an enable bit and a 14-bit clock divider. The divider slows the channel's counter by a factor of (divider + 1). A single chip-wide enable register sits above the four channels. A channel drives its pin only while both the chip-wide bit and its own enable bit are set.

New timing values written while a channel is running are held back until the current PWM cycle ends, so the output never shows a shortened or merged pulse. The register bus has no wait states. A write is accepted on the clock edge where `bus_wr` is high, and read data is a combinational function of `bus_addr`. The bus has no back-pressure, so the block has no valid/ready handshake.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: Channel n (n = 0..3) decodes at byte offset 16·n: +0x0 is the control word, +0x4 is the high-time count and +0x8 is the cycle-length count. The chip-wide enable sits at 0x3C. Control bit 0 is the channel enable, and control bits 15:2 hold the divider. The count registers use bits 15:0, and the chip-wide enable uses bit 0. Every implemented field reads back the last value written to it, and all other bits read as zero.
- R2: After reset, every register reads zero and every output is low.
- R3: An access to any other address reads zero and writes nothing. This includes an address whose two low bits are not zero, an offset of 0xC inside channels 0 to 2, and any address of 0x40 or above.
- R4: A running channel with divider P, high-time D and cycle-length N repeats every (P+1)·N clock cycles. It is high for the first (P+1)·D cycles of each repeat. The first high cycle is the one right after the write that starts the channel.
- R5: Setting the chip-wide enable does not start any channel on its own. While the chip-wide enable is clear, every output is low, whatever the channel enables hold.
- R6: A channel that is stopped has its output held low. A channel is stopped when its own enable or the chip-wide enable is clear. When it restarts, a new cycle begins from the start.
- R7: A count or divider written while a channel runs has no effect until the current cycle ends. It applies from the next cycle onward.
- R8: A high-time greater than or equal to the cycle-length keeps the output high through the whole cycle.
- R9: A high-time of 0 or a cycle-length of 0 keeps the output low.
- R10: The four channels count independently. Each one produces its own waveform at the same time as the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pwm_out | output | 4 | PWM outputs, one bit per channel |

## Verification
The bench sets up three channels, each with a different divider, high-time and cycle-length. It releases all three together with one chip-wide write and compares every output cycle against a closed-form waveform. A wrong divider reload, or counters that are shared between channels, would move the edges by one or more cycles. A second test changes the high-time in the middle of a cycle. A design without held-back copies would widen the pulse at once instead of at the next cycle boundary. A third test stops a channel part-way through a cycle and restarts it. A design that kept its counters would resume inside the old cycle and show low where a fresh high pulse is expected. The remaining tests cover misaligned and unused addresses, which would otherwise corrupt channel 0 or return stale data, and the high-time ≥ cycle-length and zero-count cases, where a bad compare would make the output flicker.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  localparam int unsigned PSC_W     = 14;  // divider field width
  localparam int unsigned CNT_W     = 16;  // high-time and cycle-length width
  localparam int unsigned PSC_LSB   = 2;   // divider position in control word
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned STRIDE_LG = 4;   // 16-byte channel stride

  // word slots inside one channel window
  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_HIGH = 2'd1,
    SLOT_LEN  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  typedef struct packed {
    logic             en;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] high;
    logic [CNT_W-1:0] len;
  } chan_cfg_t;

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output chan_cfg_t [NUM_CH-1:0]  cfg_o,
  output logic                    master_o
);

  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned UP_LSB     = STRIDE_LG + CH_W;
  localparam logic [ADDR_W-1:0] MASTER_OFF =
    ADDR_W'((NUM_CH << STRIDE_LG) - 4);

  chan_cfg_t [NUM_CH-1:0] cfg_q;
  logic                   master_q;

  logic            aligned;
  logic            upper_zero;
  logic [CH_W-1:0] ch_idx;
  slot_e           slot;
  logic            is_master;
  logic            in_chan;

  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign upper_zero = (bus_addr[ADDR_W-1:UP_LSB] == '0);
  assign ch_idx     = bus_addr[STRIDE_LG +: CH_W];
  assign slot       = slot_e'(bus_addr[3:2]);
  assign is_master  = (bus_addr == MASTER_OFF);
  assign in_chan    = aligned && upper_zero && (int'(ch_idx) < int'(NUM_CH))
                      && (slot != SLOT_NONE);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DATA_W-1:PSC_LSB+PSC_W], bus_wdata[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      master_q <= 1'b0;
    end else if (bus_wr) begin
      if (is_master) begin
        master_q <= bus_wdata[0];
      end else if (in_chan) begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (CH_W'(i) == ch_idx) begin
            case (slot)
              SLOT_CTRL: begin
                cfg_q[i].en  <= bus_wdata[0];
                cfg_q[i].psc <= bus_wdata[PSC_LSB +: PSC_W];
              end
              SLOT_HIGH: cfg_q[i].high <= bus_wdata[CNT_W-1:0];
              SLOT_LEN:  cfg_q[i].len  <= bus_wdata[CNT_W-1:0];
              default:   ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_master) begin
      bus_rdata[0] = master_q;
    end else if (in_chan) begin
      case (slot)
        SLOT_CTRL: begin
          bus_rdata[0]                 = cfg_q[ch_idx].en;
          bus_rdata[PSC_LSB +: PSC_W]  = cfg_q[ch_idx].psc;
        end
        SLOT_HIGH: bus_rdata[CNT_W-1:0] = cfg_q[ch_idx].high;
        SLOT_LEN:  bus_rdata[CNT_W-1:0] = cfg_q[ch_idx].len;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign cfg_o    = cfg_q;
  assign master_o = master_q;

endmodule

// File: rtl/pwm_quad_tick.sv
module pwm_quad_tick #(
  parameter int unsigned PSC_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] limit,
  output logic             tick_o
);

  logic [PSC_W-1:0] div_q;

  assign tick_o = run && (div_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (!run)   div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + PSC_W'(1);
  end

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_live,
  input  logic [CNT_W-1:0] high_live,
  input  logic [CNT_W-1:0] len_live,
  output logic             pwm_o
);

  logic             running_q;
  logic [PSC_W-1:0] psc_sh;
  logic [CNT_W-1:0] high_sh;
  logic [CNT_W-1:0] len_sh;
  logic [CNT_W-1:0] pos_q;

  logic [PSC_W-1:0] psc_eff;
  logic [CNT_W-1:0] high_eff;
  logic [CNT_W-1:0] len_eff;
  logic             tick;
  logic [CNT_W:0]   pos_next;
  logic             wrap;
  logic             reload;

  // first running cycle uses live values; afterwards the held copies
  assign psc_eff  = running_q ? psc_sh  : psc_live;
  assign high_eff = running_q ? high_sh : high_live;
  assign len_eff  = running_q ? len_sh  : len_live;

  pwm_quad_tick #(.PSC_W(PSC_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .limit  (psc_eff),
    .tick_o (tick)
  );

  assign pos_next = {1'b0, pos_q} + (CNT_W+1)'(1);
  assign wrap     = tick && (pos_next >= {1'b0, len_eff});
  assign reload   = !run || !running_q || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      psc_sh    <= '0;
      high_sh   <= '0;
      len_sh    <= '0;
      pos_q     <= '0;
    end else begin
      running_q <= run;
      if (reload) begin
        psc_sh  <= psc_live;
        high_sh <= high_live;
        len_sh  <= len_live;
      end
      if (!run)      pos_q <= '0;
      else if (wrap) pos_q <= '0;
      else if (tick) pos_q <= pos_next[CNT_W-1:0];
    end
  end

  assign pwm_o = run && (len_eff != '0) && (high_eff != '0) && (pos_q < high_eff);

endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  chan_cfg_t [NUM_CH-1:0] cfg;
  logic                   master_en;
  logic [NUM_CH-1:0]      ch_en;

  pwm_quad_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_o     (cfg),
    .master_o  (master_en)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign ch_en[g] = cfg[g].en;
    pwm_quad_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (master_en && cfg[g].en),
      .psc_live  (cfg[g].psc),
      .high_live (cfg[g].high),
      .len_live  (cfg[g].len),
      .pwm_o     (pwm_out[g])
    );
  end

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] ch_en,
  input logic              master_en
);

  localparam int unsigned SPAN = NUM_CH * 16;
  localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(SPAN - 4);

  logic unused_bits;
  assign unused_bits = ^bus_wdata[31:1];

  logic unmapped;
  assign unmapped = (bus_addr != MASTER_ADDR) &&
                    ((bus_addr[1:0] != 2'b00) ||
                     (int'(bus_addr) >= int'(SPAN)) ||
                     (bus_addr[3:2] == 2'b11));

  // R2: outputs low while reset is held
  p_reset_low_r2: assert property (@(posedge clk) !rst_n |-> (pwm_out == '0));

  // R5: chip-wide enable clear forces all outputs low
  p_master_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (pwm_out == '0));

  // R1: chip-wide enable register captures bit 0 of a write
  p_master_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == MASTER_ADDR) |=> (master_en == $past(bus_wdata[0])));

  // R3: unmapped reads return zero
  p_unmapped_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == '0));

  // R3: unmapped writes leave enables untouched
  p_unmapped_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unmapped) |=> ($stable(master_en) && $stable(ch_en)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_off
    // R6: a disabled channel stays low
    p_chan_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |-> !pwm_out[c]);
  end

endmodule

bind pwm_quad_ctrl pwm_quad_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .ch_en     (ch_en),
  .master_en (master_en)
);

// File: tb/test_pwm_quad_ctrl.sv
`timescale 1ns/1ps
module test_pwm_quad_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] MASTER = 8'h3C;

  always #5 clk = ~clk;

  pwm_quad_ctrl i_pwm_quad_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pwm_out   (pwm)
  );

  function automatic logic [7:0] a_ctrl(int ch); return 8'(ch * 16);     endfunction
  function automatic logic [7:0] a_high(int ch); return 8'(ch * 16 + 4); endfunction
  function automatic logic [7:0] a_len(int ch);  return 8'(ch * 16 + 8); endfunction
  function automatic logic [31:0] ctrl_word(int psc, bit en);
    return (32'(psc) << 2) | 32'(en);
  endfunction

  // expected waveform at cycle k after start (R4, R8, R9)
  function automatic logic exp_wave(int k, int p, int n, int d);
    if (n == 0 || d == 0) return 1'b0;
    return ((k / (p + 1)) % n) < d;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic run_pattern(int ch, int p, int n, int d, int cycles, string tag);
    int bad = 0;
    for (int k = 0; k < cycles; k++) begin
      if (pwm[ch] !== exp_wave(k, p, n, d)) bad++;
      @(negedge clk);
    end
    check(tag, bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R2 outputs after reset", 32'(pwm), 0);
    for (int ch = 0; ch < 4; ch++) begin
      rd_reg(a_ctrl(ch), v); check("R2 ctrl reset", v, 0);
      rd_reg(a_high(ch), v); check("R2 high reset", v, 0);
      rd_reg(a_len(ch), v);  check("R2 len reset", v, 0);
    end
    rd_reg(MASTER, v); check("R2 master reset", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr_reg(a_ctrl(2), 32'hFFFF_FFFF);
    rd_reg(a_ctrl(2), v); check("R1 ctrl readback", v, 32'h0000_FFFD);
    wr_reg(a_high(1), 32'hABCD_1234);
    rd_reg(a_high(1), v); check("R1 high readback", v, 32'h0000_1234);
    wr_reg(a_len(3), 32'h0000_FFFF);
    rd_reg(a_len(3), v); check("R1 len readback", v, 32'h0000_FFFF);
    wr_reg(MASTER, 32'hFFFF_FFFF);
    rd_reg(MASTER, v); check("R1 master readback", v, 32'h1);
    wr_reg(MASTER, 0);
    wr_reg(a_ctrl(2), 0);
    wr_reg(a_high(1), 0);
    wr_reg(a_len(3), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr_reg(a_high(0), 32'h55);
    wr_reg(8'h0C, 32'hFFFF);
    wr_reg(8'h40, 32'hFFFF);
    wr_reg(8'h05, 32'h1234);
    wr_reg(8'h01, 32'h1);
    rd_reg(8'h0C, v); check("R3 read 0x0C", v, 0);
    rd_reg(8'h40, v); check("R3 read 0x40", v, 0);
    rd_reg(8'h05, v); check("R3 read 0x05", v, 0);
    rd_reg(a_high(0), v); check("R3 high ch0 untouched", v, 32'h55);
    rd_reg(a_ctrl(0), v); check("R3 ctrl ch0 untouched", v, 0);
    rd_reg(MASTER, v);    check("R3 master untouched", v, 0);
    wr_reg(a_high(0), 0);
  endtask

  task automatic t_wave();
    int p[3] = '{1, 0, 2};
    int n[3] = '{5, 3, 4};
    int d[3] = '{2, 1, 3};
    int bad[3] = '{0, 0, 0};
    for (int ch = 0; ch < 3; ch++) begin
      wr_reg(a_len(ch), 32'(n[ch]));
      wr_reg(a_high(ch), 32'(d[ch]));
      wr_reg(a_ctrl(ch), ctrl_word(p[ch], 1'b1));
    end
    repeat (5) @(negedge clk);
    check("R5 enabled channels low without master", 32'(pwm), 0);
    wr_reg(MASTER, 1);
    for (int k = 0; k < 60; k++) begin
      for (int ch = 0; ch < 3; ch++)
        if (pwm[ch] !== exp_wave(k, p[ch], n[ch], d[ch])) bad[ch]++;
      @(negedge clk);
    end
    check("R4 R10 ch0 waveform", bad[0], 0);
    check("R4 R10 ch1 waveform", bad[1], 0);
    check("R4 R10 ch2 waveform", bad[2], 0);
    wr_reg(MASTER, 0);
    check("R5 master clear forces low", 32'(pwm), 0);
    for (int ch = 0; ch < 3; ch++) wr_reg(a_ctrl(ch), 0);
  endtask

  task automatic t_master_alone();
    wr_reg(a_len(0), 4);
    wr_reg(a_high(0), 2);
    wr_reg(MASTER, 1);
    run_pattern(0, 0, 0, 0, 20, "R5 master alone starts nothing");
    check("R5 all outputs low", 32'(pwm), 0);
  endtask

  task automatic t_restart();
    wr_reg(a_len(0), 6);
    wr_reg(a_high(0), 3);
    wr_reg(a_ctrl(0), ctrl_word(0, 1'b1));
    run_pattern(0, 0, 6, 3, 4, "R4 ch0 before stop");
    wr_reg(a_ctrl(0), 0);
    check("R6 output low after stop", 32'(pwm[0]), 0);
    run_pattern(0, 0, 0, 0, 3, "R6 stays low while stopped");
    wr_reg(a_ctrl(0), ctrl_word(0, 1'b1));
    run_pattern(0, 0, 6, 3, 12, "R6 restart begins fresh cycle");
    wr_reg(a_ctrl(0), 0);
  endtask

  task automatic t_shadow();
    logic exp_seq[6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
    int bad = 0;
    wr_reg(a_len(1), 4);
    wr_reg(a_high(1), 1);
    wr_reg(a_ctrl(1), ctrl_word(0, 1'b1));
    check("R7 first cycle high", 32'(pwm[1]), 1);
    @(negedge clk);
    check("R7 second cycle low", 32'(pwm[1]), 0);
    wr_reg(a_high(1), 3);
    for (int k = 0; k < 6; k++) begin
      if (pwm[1] !== exp_seq[k]) bad++;
      @(negedge clk);
    end
    check("R7 new high-time waits for boundary", bad, 0);
    wr_reg(a_ctrl(1), 0);
  endtask

  task automatic t_full_and_zero();
    wr_reg(a_len(3), 5);
    wr_reg(a_high(3), 7);
    wr_reg(a_ctrl(3), ctrl_word(0, 1'b1));
    run_pattern(3, 0, 1, 1, 20, "R8 high-time above length stays high");
    wr_reg(a_high(3), 5);
    repeat (6) @(negedge clk);
    run_pattern(3, 0, 1, 1, 15, "R8 high-time equal length stays high");
    wr_reg(a_high(3), 0);
    repeat (6) @(negedge clk);
    run_pattern(3, 0, 0, 0, 15, "R9 zero high-time low");
    wr_reg(a_ctrl(3), 0);
    wr_reg(a_high(3), 3);
    wr_reg(a_len(3), 0);
    wr_reg(a_ctrl(3), ctrl_word(1, 1'b1));
    run_pattern(3, 0, 0, 0, 15, "R9 zero length low");
    wr_reg(a_ctrl(3), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_wave();
    t_master_alone();
    t_restart();
    t_shadow();
    t_full_and_zero();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule